// File: doc/BRIEF.md
# Tank Fill and Drain Sequencer

This block is a clocked controller for a mixing tank that has two limit switches: one at the bottom that reports a low level and one at the top that reports a high level. When enabled by a start input and the tank reads low, the block opens the inlet valve and runs the mixer motor together. It keeps them on until the top switch trips. It then closes the inlet, stops the motor and opens the bottom drain valve. When the low level is reached again it refills, so the tank cycles between the two switches with hysteresis.

Each valve returns a position flag. If a flag disagrees with its valve's command for longer than a set number of cycles, the block latches a fault and turns every output off until reset. All five inputs are asynchronous to the clock and pass through a two-flop synchronizer before the logic uses them.

Top module: `tank_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, motor, inlet, drain and fault outputs are all 0.
- R2: With start at 0 the controller is idle and motor, inlet and drain stay 0 whatever the level switches read.
- R3: From idle, a synchronized start of 1 with the low switch at 1 (1 = tank low) enters filling: motor and inlet 1, drain 0. With start at 1 and the low switch at 0, the controller enters draining instead.
- R4: Filling continues while the high switch (1 = tank high) is 0 and switches to draining when it reads 1: inlet and motor go to 0 and drain goes to 1 on the same edge.
- R5: Draining continues while the low switch is 0 and returns to filling when it reads 1, so fill and drain alternate without limit.
- R6: Start falling to 0 returns the controller to idle from filling or draining, with all three enables at 0.
- R7: Inlet and drain are never 1 together, and motor always equals inlet.
- R8: An input change takes effect at the outputs on the third rising clock edge after it is applied, and not on the second.
- R9: Feedback flags read 1 when a valve is open. A mismatch between a flag and its valve command seen on FB_LIMIT consecutive synchronized cycles causes no fault; on FB_LIMIT+1 consecutive cycles fault goes to 1. This applies to the inlet and the drain valve separately.
- R10: Once fault is 1 it stays 1 and motor, inlet and drain stay 0 until reset, whatever start and the switches do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Process enable, asynchronous |
| low_sw_i | input | 1 | Bottom level switch, 1 = tank low |
| high_sw_i | input | 1 | Top level switch, 1 = tank high |
| inlet_fb_i | input | 1 | Inlet valve position flag, 1 = open |
| drain_fb_i | input | 1 | Drain valve position flag, 1 = open |
| motor_o | output | 1 | Mixer motor enable |
| inlet_o | output | 1 | Inlet valve enable |
| drain_o | output | 1 | Drain valve enable |
| fault_o | output | 1 | Latched valve feedback fault |

## Verification
The assertions assume that each valve flag follows its command within FB_LIMIT synchronized cycles. Otherwise the fault path overrides normal sequencing, and the hold properties allow for that override. The bench makes the flags follow the enables one half-cycle after each change, which gives a two-cycle mismatch per transition. It breaks that tracking only on purpose, in the fault sweep, where it holds a flag wrong for 1 to FB_LIMIT+1 cycles. Switch levels change only at falling edges and are held long enough to pass the synchronizer. The only idle sweep that covers all four switch combinations keeps the valve flags at 0.

// File: rtl/tank_seq.sv
module tank_seq #(
  parameter int FB_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic low_sw_i,
  input  logic high_sw_i,
  input  logic inlet_fb_i,
  input  logic drain_fb_i,
  output logic motor_o,
  output logic inlet_o,
  output logic drain_o,
  output logic fault_o
);

  localparam int CW = $clog2(FB_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(FB_LIMIT);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_DRAIN} st_t;

  logic [4:0] sy1, sy2;
  logic s_start, s_low, s_high, s_ifb, s_dfb;
  st_t st, st_nx;
  logic fault;
  logic [CW-1:0] cnt_in, cnt_dr;
  logic mis_in, mis_dr, fault_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {start_i, low_sw_i, high_sw_i, inlet_fb_i, drain_fb_i};
      sy2 <= sy1;
    end
  end

  assign {s_start, s_low, s_high, s_ifb, s_dfb} = sy2;

  assign inlet_o = (st == ST_FILL);
  assign motor_o = (st == ST_FILL);
  assign drain_o = (st == ST_DRAIN);
  assign fault_o = fault;

  assign mis_in = (s_ifb != inlet_o);
  assign mis_dr = (s_dfb != drain_o);
  assign fault_set = (mis_in && cnt_in == LIM) || (mis_dr && cnt_dr == LIM);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  st_nx = s_low ? ST_FILL : ST_DRAIN;
      ST_FILL:  if (s_high) st_nx = ST_DRAIN;
      ST_DRAIN: if (s_low) st_nx = ST_FILL;
      default:  st_nx = ST_IDLE;
    endcase
    if (!s_start || fault || fault_set) st_nx = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      fault  <= 1'b0;
      cnt_in <= '0;
      cnt_dr <= '0;
    end else begin
      st     <= st_nx;
      fault  <= fault | fault_set;
      cnt_in <= !mis_in ? '0 : (cnt_in == LIM ? cnt_in : cnt_in + 1'b1);
      cnt_dr <= !mis_dr ? '0 : (cnt_dr == LIM ? cnt_dr : cnt_dr + 1'b1);
    end
  end

  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !s_start |=> (st == ST_IDLE));

  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);

  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> (!motor_o && !inlet_o && !drain_o));

  p_fill_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inlet_o) |-> $past(s_low));

  p_drain_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_o) |-> ($past(s_high) || $past(st == ST_IDLE)));

  p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL && s_start && !s_high && !fault_set) |=> inlet_o);

  p_drain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN && s_start && !s_low && !fault_set) |=> drain_o);

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_in <= LIM) && (cnt_dr <= LIM));

endmodule

// File: tb/tank_seq_tb.sv
module tank_seq_tb;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, low_sw_i = 0, high_sw_i = 0, inlet_fb_i = 0, drain_fb_i = 0;
  logic motor_o, inlet_o, drain_o, fault_o;
  logic auto_in = 1'b1, auto_dr = 1'b1;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tank_seq #(.FB_LIMIT(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .low_sw_i(low_sw_i),
    .high_sw_i(high_sw_i), .inlet_fb_i(inlet_fb_i), .drain_fb_i(drain_fb_i),
    .motor_o(motor_o), .inlet_o(inlet_o), .drain_o(drain_o), .fault_o(fault_o));

  // outputs as {fault, motor, inlet, drain}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {fault_o, motor_o, inlet_o, drain_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (auto_in) inlet_fb_i = inlet_o;
      if (auto_dr) drain_fb_i = drain_o;
      checks++;
      if ((inlet_o && drain_o) || (motor_o !== inlet_o)) begin
        errors++;
        $display("FAIL R7: motor=%b inlet=%b drain=%b expected exclusive and motor==inlet",
                 motor_o, inlet_o, drain_o);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_i = 0; low_sw_i = 0; high_sw_i = 0;
    auto_in = 1; auto_dr = 1; inlet_fb_i = 0; drain_fb_i = 0;
    tick(2);
    chk("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    tick(1);
    chk("R1 after reset", 4'b0000);
  endtask

  localparam logic [3:0] OFF = 4'b0000, FILL = 4'b0110, DRAIN = 4'b0001, FLT = 4'b1000;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R2 idle sweep over every switch combination
    for (int c = 0; c < 4; c++) begin
      {low_sw_i, high_sw_i} = c[1:0];
      tick(4);
      chk("R2 idle with start low", OFF);
    end

    // R3 + R8: start with tank low -> fill on third edge
    low_sw_i = 1; high_sw_i = 0; tick(1);
    start_i = 1;
    tick(2); chk("R8 no change after two edges", OFF);
    tick(1); chk("R3 start with low enters fill", FILL);

    // R4 / R5 cycling several times
    for (int k = 0; k < 3; k++) begin
      low_sw_i = 0; tick(4);
      chk("R4 fill holds while not high", FILL);
      high_sw_i = 1;
      tick(2); chk("R8 fill before third edge", FILL);
      tick(1); chk("R4 high ends fill, drain opens", DRAIN);
      high_sw_i = 0; tick(4);
      chk("R5 drain holds while not low", DRAIN);
      low_sw_i = 1;
      tick(2); chk("R8 drain before third edge", DRAIN);
      tick(1); chk("R5 low reached, refill", FILL);
    end

    // R6 start drop during fill
    start_i = 0; tick(3); chk("R6 stop from fill", OFF);
    // R3 start with tank not low -> drain first
    low_sw_i = 0; high_sw_i = 0; tick(2);
    start_i = 1; tick(3); chk("R3 start with not low enters drain", DRAIN);
    start_i = 0; tick(3); chk("R6 stop from drain", OFF);
    tick(4);

    // R9 inlet mismatch sweep: up to L cycles tolerated
    low_sw_i = 1; start_i = 1; tick(6);
    chk("R3 fill before fault sweep", FILL);
    for (int d = 1; d <= L; d++) begin
      auto_in = 0; inlet_fb_i = 0;
      tick(d);
      auto_in = 1; inlet_fb_i = 1;
      tick(5);
      chk($sformatf("R9 inlet mismatch %0d cycles no fault", d), FILL);
    end
    auto_in = 0; inlet_fb_i = 0;
    tick(L + 2); chk("R9 inlet mismatch L+1 not yet", FILL);
    tick(1); chk("R9 inlet mismatch L+1 faults", FLT);
    auto_in = 1;
    // R10 sticky, start ignored
    start_i = 0; tick(4); start_i = 1; tick(6);
    chk("R10 fault sticky with start toggled", FLT);
    high_sw_i = 1; low_sw_i = 0; tick(6);
    chk("R10 switches ignored under fault", FLT);

    // R9 drain valve mismatch
    do_reset();
    start_i = 1; tick(6);
    chk("R3 drain before drain fault", DRAIN);
    auto_dr = 0; drain_fb_i = 0;
    tick(L + 2); chk("R9 drain mismatch L+1 not yet", DRAIN);
    tick(1); chk("R9 drain mismatch L+1 faults", FLT);
    auto_dr = 1;
    tick(5); chk("R10 drain fault holds", FLT);
    do_reset();
    chk("R1 reset clears fault", OFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule